// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block sits next to the control path of a small processor and decides, at every instruction boundary, which pending event the core may take. It owns the state that masks those events. This state is the interrupt-enable bit, the resume bit that masks debug faults, the latched non-maskable request and its in-service flag, and a one-boundary shadow armed by any write of the stack segment. The decoder drives one-cycle event pulses into the block, and the block turns them into updates of that state.

At a boundary cycle the block looks at five request classes and raises at most one accept pulse in the same cycle. The classes are page or protection faults, the non-maskable request, debug faults, single-step traps and the maskable level request. Software can change the enable bit in three ways. It can use the clear and set events, which are subject to a privilege comparison and raise a protection-fault pulse when refused. It can load the whole flag word. Gate entry also clears the bit. The live enable and resume bits are driven out for the rest of the core.

Top module: `intGate`

## Requirements
- R1: Accept pulses (acceptFault, acceptNmi, acceptDbg, acceptStep, acceptIntr) are combinational and can be high only in a cycle where boundary is high. With boundary low all five are 0.
- R2: A rising edge on nmiIn sets a pending non-maskable request, and that request is held until it is accepted. Accepting it sets an in-service state. While in service, rising edges on nmiIn are dropped and are not remembered. An iretEv pulse ends the in-service state.
- R3: The maskable request intrIn is a level and is never latched. It is accepted only at a boundary where the enable bit ifFlag is 1.
- R4: After reset, ifFlag and rfFlag are 0, no non-maskable request is pending or in service, the shadow is clear, and all pulses are 0.
- R5: cliEv clears ifFlag and stiEv sets it on the next clock, but only when cpl <= iopl. When cpl > iopl, ifFlag keeps its value and privFault is 1 in the same cycle as the event.
- R6: flagLoad writes ifFlag from flagWord bit 9 and rfFlag from flagWord bit 16. gateEntry clears ifFlag. If events coincide, the order for ifFlag is flagLoad, then gateEntry, then stiEv, then cliEv.
- R7: While rfFlag is 1, a debug-fault request is not accepted. Single-step requests are unaffected by rfFlag.
- R8: rfFlag is cleared on the clock after an instDone pulse, unless a flagLoad occurs in the same cycle; in that case the load wins.
- R9: An ssWrite pulse arms a shadow. At the next boundary the shadow blocks the non-maskable, debug, step and maskable classes. A pending non-maskable request survives the shadow and can be taken at the following boundary.
- R10: A page or protection fault request (faultReq) is accepted at any boundary, including a shadowed one.
- R11: When several classes are acceptable at one boundary, only the highest is accepted. The order from highest to lowest is fault, non-maskable, debug, step, maskable.
- R12: Any boundary clears the shadow, whether or not something was accepted. An ssWrite in the same cycle as a boundary re-arms it for the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction (or string-repetition) boundary strobe |
| nmiIn | input | 1 | Raw non-maskable request line, edge sensitive |
| intrIn | input | 1 | Maskable request line, level sensitive |
| dbgReq | input | 1 | Debug-fault request |
| stepReq | input | 1 | Single-step trap request |
| faultReq | input | 1 | Page or protection fault request |
| cliEv | input | 1 | Decoder pulse: clear enable bit |
| stiEv | input | 1 | Decoder pulse: set enable bit |
| flagLoad | input | 1 | Decoder pulse: load flag word |
| flagWord | input | FLAG_W | Flag word value for flagLoad |
| gateEntry | input | 1 | Pulse: entry through an interrupt gate |
| iretEv | input | 1 | Pulse: interrupt return |
| ssWrite | input | 1 | Pulse: stack segment written |
| instDone | input | 1 | Pulse: instruction completed successfully |
| cpl | input | PL_W | Current privilege level |
| iopl | input | PL_W | I/O privilege level |
| acceptFault | output | 1 | Fault accepted |
| acceptNmi | output | 1 | Non-maskable request accepted |
| acceptDbg | output | 1 | Debug fault accepted |
| acceptStep | output | 1 | Single-step trap accepted |
| acceptIntr | output | 1 | Maskable request accepted |
| privFault | output | 1 | Protection fault from refused clear/set |
| ifFlag | output | 1 | Live interrupt-enable bit |
| rfFlag | output | 1 | Live resume bit |

## Verification
The arbitration is swept over all 256 combinations of enable bit, resume bit, shadow, pending non-maskable request and the four request lines. Each combination is set up from reset through the ports, and the single expected accept is computed from the priority order. This separates masking faults from ordering faults. The same sweep steps one boundary further after every shadowed case, which separates a shadow that lasts one boundary from one that sticks or loses the pending request. A 16-point sweep of privilege pairs tells apart an inverted or off-by-one privilege comparison. Directed sequences cover dropped edges while in service, the level nature of the maskable line, event precedence on the enable and resume bits, and shadow re-arming.

// File: rtl/intGatePkg.sv
package intGatePkg;

  // request class positions, index 0 is the highest priority
  localparam int CLS_FAULT = 0;
  localparam int CLS_NMI   = 1;
  localparam int CLS_DBG   = 2;
  localparam int CLS_STEP  = 3;
  localparam int CLS_INTR  = 4;
  localparam int NCLS      = 5;

  // strobes from control to the state datapath
  typedef struct packed {
    logic takeNmi;
    logic endNmi;
    logic setShadow;
    logic clrShadow;
    logic loadFlags;
    logic gateClr;
    logic setIf;
    logic clrIf;
    logic clrRf;
  } gateStrobeT;

  // mask state seen by control
  typedef struct packed {
    logic ifFlag;
    logic rfFlag;
    logic nmiPend;
    logic nmiBusy;
    logic shadow;
  } gateStateT;

endpackage

// File: rtl/intGateCtrl.sv
module intGateCtrl
  import intGatePkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic             intrIn,
  input  logic             dbgReq,
  input  logic             stepReq,
  input  logic             faultReq,
  input  logic             cliEv,
  input  logic             stiEv,
  input  logic             flagLoad,
  input  logic             gateEntry,
  input  logic             iretEv,
  input  logic             ssWrite,
  input  logic             instDone,
  input  logic [PL_W-1:0]  cpl,
  input  logic [PL_W-1:0]  iopl,
  input  gateStateT        st,
  output logic [NCLS-1:0]  grant,
  output logic             privFault,
  output gateStrobeT       strobe
);

  logic privOk;
  logic openGate;
  logic [NCLS-1:0] req;

  assign privOk   = (cpl <= iopl);
  assign openGate = boundary & ~st.shadow;

  always_comb begin
    req             = '0;
    req[CLS_FAULT]  = boundary & faultReq;
    req[CLS_NMI]    = openGate & st.nmiPend & ~st.nmiBusy;
    req[CLS_DBG]    = openGate & dbgReq & ~st.rfFlag;
    req[CLS_STEP]   = openGate & stepReq;
    req[CLS_INTR]   = openGate & intrIn & st.ifFlag;
  end

  // fixed-priority pick, lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (req[k] && !taken) begin
        grant[k] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign privFault = (cliEv | stiEv) & ~privOk;

  always_comb begin
    strobe           = '0;
    strobe.takeNmi   = grant[CLS_NMI];
    strobe.endNmi    = iretEv;
    strobe.setShadow = ssWrite;
    strobe.clrShadow = boundary;
    strobe.loadFlags = flagLoad;
    strobe.gateClr   = gateEntry;
    strobe.setIf     = stiEv & privOk;
    strobe.clrIf     = cliEv & privOk;
    strobe.clrRf     = instDone;
  end

  // R11
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R1
  grant_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0) |-> boundary);

  // R3
  intr_needs_if_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant[CLS_INTR] |-> st.ifFlag);

  // R7
  dbg_needs_clear_rf_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant[CLS_DBG] |-> !st.rfFlag);

  // R9
  shadow_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && st.shadow) |-> (grant[NCLS-1:CLS_NMI] == '0));

  // R5
  refused_keeps_if_chk: assert property (@(posedge clk) disable iff (!rstN)
    (privFault && !flagLoad && !gateEntry) |=> $stable(st.ifFlag));

endmodule

// File: rtl/intGateData.sv
module intGateData
  import intGatePkg::*;
#(
  parameter int FLAG_W = 32,
  parameter int IF_POS = 9,
  parameter int RF_POS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiIn,
  input  logic [FLAG_W-1:0] flagWord,
  input  gateStrobeT        strobe,
  output gateStateT         st
);

  logic nmiPrev;
  logic nmiRise;
  logic unusedFlagBits;

  assign nmiRise        = nmiIn & ~nmiPrev;
  assign unusedFlagBits = ^flagWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      st      <= '0;
    end else begin
      nmiPrev <= nmiIn;

      if (strobe.takeNmi)
        st.nmiPend <= 1'b0;
      else if (nmiRise && !st.nmiBusy)
        st.nmiPend <= 1'b1;

      if (strobe.takeNmi)
        st.nmiBusy <= 1'b1;
      else if (strobe.endNmi)
        st.nmiBusy <= 1'b0;

      if (strobe.loadFlags)
        st.ifFlag <= flagWord[IF_POS];
      else if (strobe.gateClr)
        st.ifFlag <= 1'b0;
      else if (strobe.setIf)
        st.ifFlag <= 1'b1;
      else if (strobe.clrIf)
        st.ifFlag <= 1'b0;

      if (strobe.loadFlags)
        st.rfFlag <= flagWord[RF_POS];
      else if (strobe.clrRf)
        st.rfFlag <= 1'b0;

      if (strobe.setShadow)
        st.shadow <= 1'b1;
      else if (strobe.clrShadow)
        st.shadow <= 1'b0;
    end
  end

  // R2
  busy_from_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.nmiBusy) |-> $past(strobe.takeNmi));

  // R6
  gate_clears_if_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.gateClr && !strobe.loadFlags) |=> !st.ifFlag);

  // R8
  done_clears_rf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrRf && !strobe.loadFlags) |=> !st.rfFlag);

  // R12
  shadow_one_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrShadow && !strobe.setShadow) |=> !st.shadow);

endmodule

// File: rtl/intGate.sv
module intGate
  import intGatePkg::*;
#(
  parameter int FLAG_W = 32,
  parameter int IF_POS = 9,
  parameter int RF_POS = 16,
  parameter int PL_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              boundary,
  input  logic              nmiIn,
  input  logic              intrIn,
  input  logic              dbgReq,
  input  logic              stepReq,
  input  logic              faultReq,
  input  logic              cliEv,
  input  logic              stiEv,
  input  logic              flagLoad,
  input  logic [FLAG_W-1:0] flagWord,
  input  logic              gateEntry,
  input  logic              iretEv,
  input  logic              ssWrite,
  input  logic              instDone,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   iopl,
  output logic              acceptFault,
  output logic              acceptNmi,
  output logic              acceptDbg,
  output logic              acceptStep,
  output logic              acceptIntr,
  output logic              privFault,
  output logic              ifFlag,
  output logic              rfFlag
);

  gateStateT       st;
  gateStrobeT      strobe;
  logic [NCLS-1:0] grant;

  intGateCtrl #(.PL_W(PL_W)) ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .intrIn(intrIn),
    .dbgReq(dbgReq), .stepReq(stepReq), .faultReq(faultReq),
    .cliEv(cliEv), .stiEv(stiEv), .flagLoad(flagLoad),
    .gateEntry(gateEntry), .iretEv(iretEv), .ssWrite(ssWrite),
    .instDone(instDone), .cpl(cpl), .iopl(iopl), .st(st),
    .grant(grant), .privFault(privFault), .strobe(strobe)
  );

  intGateData #(.FLAG_W(FLAG_W), .IF_POS(IF_POS), .RF_POS(RF_POS)) data (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .flagWord(flagWord),
    .strobe(strobe), .st(st)
  );

  assign acceptFault = grant[CLS_FAULT];
  assign acceptNmi   = grant[CLS_NMI];
  assign acceptDbg   = grant[CLS_DBG];
  assign acceptStep  = grant[CLS_STEP];
  assign acceptIntr  = grant[CLS_INTR];
  assign ifFlag      = st.ifFlag;
  assign rfFlag      = st.rfFlag;

endmodule

// File: tb/intGate_test.sv
module intGate_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic boundary, nmiIn, intrIn, dbgReq, stepReq, faultReq;
  logic cliEv, stiEv, flagLoad, gateEntry, iretEv, ssWrite, instDone;
  logic [31:0] flagWord;
  logic [1:0] cpl, iopl;
  logic acceptFault, acceptNmi, acceptDbg, acceptStep, acceptIntr;
  logic privFault, ifFlag, rfFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intGate uut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiIn(nmiIn),
    .intrIn(intrIn), .dbgReq(dbgReq), .stepReq(stepReq),
    .faultReq(faultReq), .cliEv(cliEv), .stiEv(stiEv),
    .flagLoad(flagLoad), .flagWord(flagWord), .gateEntry(gateEntry),
    .iretEv(iretEv), .ssWrite(ssWrite), .instDone(instDone),
    .cpl(cpl), .iopl(iopl), .acceptFault(acceptFault),
    .acceptNmi(acceptNmi), .acceptDbg(acceptDbg), .acceptStep(acceptStep),
    .acceptIntr(acceptIntr), .privFault(privFault), .ifFlag(ifFlag),
    .rfFlag(rfFlag)
  );

  // accept vector as {intr, step, dbg, nmi, fault}
  function automatic logic [4:0] acc();
    return {acceptIntr, acceptStep, acceptDbg, acceptNmi, acceptFault};
  endfunction

  function automatic logic [4:0] expAcc(logic ifv, logic rfv, logic sh,
      logic np, logic dq, logic sq, logic iq, logic fq);
    if (fq) return 5'b00001;
    if (sh) return 5'b00000;
    if (np) return 5'b00010;
    if (dq && !rfv) return 5'b00100;
    if (sq) return 5'b01000;
    if (iq && ifv) return 5'b10000;
    return 5'b00000;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    boundary = 0; nmiIn = 0; intrIn = 0; dbgReq = 0; stepReq = 0;
    faultReq = 0; cliEv = 0; stiEv = 0; flagLoad = 0; gateEntry = 0;
    iretEv = 0; ssWrite = 0; instDone = 0; flagWord = '0;
    cpl = 0; iopl = 0;
  endtask

  task automatic doReset();
    clearIn();
    rstN = 0;
    cyc(); cyc();
    rstN = 1;
  endtask

  task automatic loadFlags(logic ifv, logic rfv);
    flagWord = '0; flagWord[9] = ifv; flagWord[16] = rfv;
    flagLoad = 1; cyc(); flagLoad = 0; flagWord = '0;
  endtask

  task automatic pulseNmi();
    nmiIn = 1; cyc(); nmiIn = 0; cyc();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    doReset();
    // R4 reset state
    #1;
    check("R4 ifFlag", ifFlag, 0);
    check("R4 rfFlag", rfFlag, 0);
    check("R4 accepts", acc(), 0);
    check("R4 privFault", privFault, 0);
    boundary = 1; intrIn = 1; dbgReq = 1; #1;
    check("R4 no pending nmi, debug taken", acc(), 5'b00100);
    clearIn();

    // R3/R7/R9/R10/R11/R12 arbitration sweep
    for (int c = 0; c < 256; c++) begin
      logic ifv, rfv, sh, np, dq, sq, iq, fq;
      logic [4:0] e;
      {fq, iq, sq, dq, np, sh, rfv, ifv} = 8'(c);
      doReset();
      loadFlags(ifv, rfv);
      if (np) pulseNmi();
      if (sh) begin ssWrite = 1; cyc(); ssWrite = 0; end
      dbgReq = dq; stepReq = sq; intrIn = iq; faultReq = fq;
      boundary = 1; #1;
      e = expAcc(ifv, rfv, sh, np, dq, sq, iq, fq);
      check($sformatf("R3/R7/R9/R10/R11 case %0d", c), acc(), e);
      cyc();
      boundary = 0; #1;
      check($sformatf("R1 case %0d", c), acc(), 0);
      if (sh) begin
        boundary = 1; #1;
        e = expAcc(ifv, rfv, 1'b0, np, dq, sq, iq, fq);
        check($sformatf("R9/R12 after shadow case %0d", c), acc(), e);
        cyc();
      end
      clearIn();
    end

    // R5 privilege sweep for set and clear
    for (int p = 0; p < 16; p++) begin
      logic [1:0] cp, io;
      {cp, io} = 4'(p);
      doReset();
      cpl = cp; iopl = io; stiEv = 1; #1;
      check($sformatf("R5 sti privFault cpl%0d iopl%0d", cp, io), privFault, cp > io);
      cyc(); stiEv = 0; #1;
      check($sformatf("R5 sti ifFlag cpl%0d iopl%0d", cp, io), ifFlag, cp <= io);
      loadFlags(1, 0);
      cliEv = 1; #1;
      check($sformatf("R5 cli privFault cpl%0d iopl%0d", cp, io), privFault, cp > io);
      cyc(); cliEv = 0; #1;
      check($sformatf("R5 cli ifFlag cpl%0d iopl%0d", cp, io), ifFlag, cp > io);
    end

    // R6 gate entry and precedence
    doReset();
    loadFlags(1, 0);
    check("R6 load sets if", ifFlag, 1);
    gateEntry = 1; cyc(); gateEntry = 0; #1;
    check("R6 gate clears if", ifFlag, 0);
    flagWord[9] = 1; flagLoad = 1; gateEntry = 1; cyc();
    flagLoad = 0; gateEntry = 0; flagWord = '0; #1;
    check("R6 load beats gate", ifFlag, 1);
    gateEntry = 1; stiEv = 1; cyc(); gateEntry = 0; stiEv = 0; #1;
    check("R6 gate beats sti", ifFlag, 0);
    stiEv = 1; cliEv = 1; cyc(); stiEv = 0; cliEv = 0; #1;
    check("R6 sti beats cli", ifFlag, 1);

    // R8 resume bit
    loadFlags(1, 1);
    check("R8 load sets rf", rfFlag, 1);
    boundary = 1; dbgReq = 1; stepReq = 1; #1;
    check("R7 rf blocks debug, step taken", acc(), 5'b01000);
    cyc(); boundary = 0; dbgReq = 0; stepReq = 0;
    check("R8 rf held without done", rfFlag, 1);
    instDone = 1; cyc(); instDone = 0; #1;
    check("R8 done clears rf", rfFlag, 0);
    flagWord[16] = 1; flagLoad = 1; instDone = 1; cyc();
    flagLoad = 0; instDone = 0; flagWord = '0; #1;
    check("R8 load beats done", rfFlag, 1);

    // R2 in-service masking
    doReset();
    pulseNmi();
    boundary = 1; #1;
    check("R2 first nmi taken", acc(), 5'b00010);
    cyc(); boundary = 0;
    pulseNmi();
    boundary = 1; stepReq = 1; #1;
    check("R2 nmi dropped while busy", acc(), 5'b01000);
    cyc(); boundary = 0; stepReq = 0;
    iretEv = 1; cyc(); iretEv = 0;
    boundary = 1; #1;
    check("R2 dropped edge not remembered", acc(), 0);
    cyc(); boundary = 0;
    pulseNmi();
    boundary = 1; #1;
    check("R2 nmi taken after iret", acc(), 5'b00010);
    cyc(); boundary = 0;
    nmiIn = 1; cyc(); cyc(); cyc(); iretEv = 1; cyc(); iretEv = 0;
    boundary = 1; #1;
    check("R2 held level is not an edge", acc(), 0);
    cyc(); clearIn();

    // R3 level not latched
    doReset();
    loadFlags(1, 0);
    intrIn = 1; cyc(); intrIn = 0;
    boundary = 1; #1;
    check("R3 intr not latched", acc(), 0);
    intrIn = 1; #1;
    check("R3 intr level taken", acc(), 5'b10000);
    cyc(); clearIn();

    // R12 shadow re-armed by write at a boundary
    doReset();
    loadFlags(1, 0);
    ssWrite = 1; cyc();
    boundary = 1; intrIn = 1; #1;
    check("R12 shadow boundary blocks", acc(), 0);
    cyc();
    ssWrite = 0; #1;
    check("R12 rearmed blocks", acc(), 0);
    cyc(); #1;
    check("R12 shadow gone", acc(), 5'b10000);
    faultReq = 1; ssWrite = 1; cyc(); ssWrite = 0; #1;
    check("R10 fault in shadow", acc(), 5'b00001);
    cyc(); clearIn();

    finished = 1'b1;
    summary();
  end

endmodule